// File: doc/BRIEF.md
# Interrupt Redirection Table Dispatcher

This block turns interrupt input pins into interrupt messages. A table of 64-bit redirection entries holds one entry for each pin. Software fills the table through a register port. A scan pointer visits the pins one per cycle in round-robin order. When the visited pin is unmasked and has something to deliver, the block registers one message. The message carries the vector, the delivery mode, the destination mode and the destination, and it is offered on a valid/ready output. The scan waits while a message is offered.

The delivery mode decides how the trigger bit is used. Fixed and lowest-priority entries may be edge- or level-triggered. A level entry of either kind sets its remote-IRR bit when its message is taken. It then stays quiet until an end-of-interrupt arrives with the entry's vector. SMI and ExtINT entries always behave as edge-triggered. An NMI or INIT entry wrongly set to level never sets remote-IRR. While its pin stays high, it fires again on every lap of the scan. An ExtINT message raises a flag telling the receiver that an external legacy controller supplies the vector.

Top module: `irq_redir_dispatch`

## Requirements
- R1: After reset no message is offered, and every entry reads back as 64'h0000_0000_0001_0000, which is masked with all other bits zero.
- R2: A write to an index below NUM_PINS stores all 64 bits except bit 14. A read returns the stored entry with bit 14 replaced by the live remote-IRR flag. Writes to higher indices are ignored, and reads there return zero.
- R3: The entry fields are vector in bits 7:0, delivery mode in 10:8, destination mode in 11 (0 = physical), remote-IRR in 14, trigger in 15 (0 = edge, 1 = level), mask in 16 (1 = masked) and destination in 63:56. A rising edge on an unmasked edge pin gives exactly one message. Holding the pin high afterwards gives no further message.
- R4: A rising edge on a masked pin sends nothing but is remembered. The message is sent once the entry is unmasked.
- R5: The message destination is bits 63:56 in logical mode. In physical mode it is {4'b0, bits 59:56}.
- R6: For a level-triggered fixed (000) or lowest-priority (001) entry, a message is sent while the pin is high and remote-IRR is clear. Acceptance sets remote-IRR and blocks that pin. Only an end-of-interrupt whose vector equals the entry's vector clears it.
- R7: An NMI (100) or INIT (101) entry set to level never sets remote-IRR. While its pin is high it sends a message every time the scan reaches it.
- R8: SMI (010) entries are edge-triggered even with the trigger bit set. SMI and NMI messages carry vector 0.
- R9: The external-acknowledge flag is high exactly for ExtINT (111) messages. ExtINT is always edge-triggered.
- R10: Entries with the reserved modes 011 or 110 never send a message.
- R11: An offered message and its fields stay unchanged until msg_ready_i is sampled high.
- R12: Several pins pending together are served in cyclic ascending pin order, starting from the scan position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_PINS | Interrupt input pins |
| reg_we_i | input | 1 | Table write strobe |
| reg_addr_i | input | IDX_W | Entry index for read and write |
| reg_wdata_i | input | 64 | Entry write data |
| reg_rdata_o | output | 64 | Entry read data, bit 14 = remote-IRR |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | End-of-interrupt vector |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message taken when high with valid |
| msg_vector_o | output | 8 | Message vector |
| msg_mode_o | output | 3 | Message delivery mode |
| msg_dest_logical_o | output | 1 | Message destination mode, 1 = logical |
| msg_dest_o | output | 8 | Message destination |
| msg_ext_o | output | 1 | Vector comes from the external controller |

## Verification
The assertions assume that each pin's entry is programmed before the pin toggles. They also assume that the receiver may hold msg_ready_i low for any time, and that end-of-interrupt vectors name level entries that are really waiting. The stimulus writes an entry while its pin is low and drives each pin only after programming it. It masks entries again once their message has been taken. Random trials use edge entries on a separate group of pins, with random vectors, modes and destinations, so directed level and reserved-mode cases leave no stale state behind.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int ENTRY_W  = 64;
  localparam int MODE_LSB = 8;
  localparam int DSTM_BIT = 11;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWEST = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV6   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  function automatic logic mode_reserved(logic [2:0] m);
    return (m == DM_RSV3) || (m == DM_RSV6);
  endfunction

  // modes whose trigger bit is overridden to edge
  function automatic logic mode_edge_only(logic [2:0] m);
    return (m == DM_SMI) || (m == DM_EXTINT);
  endfunction

  function automatic logic mode_uses_rirr(logic [2:0] m);
    return (m == DM_FIXED) || (m == DM_LOWEST);
  endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   addr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  output logic [ENTRY_W-1:0] tbl_o [NUM_PINS]
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_o[g] <= ENTRY_RST;
      else if (we_i && addr_i == IDX_W'(g)) tbl_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] rise;
  assign rise = irq_i & ~lvl_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= '0;
      pend_o <= '0;
    end else begin
      lvl_o  <= irq_i;
      pend_o <= (pend_o & ~clr_i) | rise;  // new edge wins over clear
    end
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i)); // R3
  AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_o & $past(rise)) == $past(rise))); // R4
endmodule

// File: rtl/irq_redir_scan.sv
module irq_redir_scan
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0][7:0]  vec_i,
  input  logic [NUM_PINS-1:0][2:0]  mode_i,
  input  logic [NUM_PINS-1:0]       dl_i,
  input  logic [NUM_PINS-1:0]       trig_i,
  input  logic [NUM_PINS-1:0]       mask_i,
  input  logic [NUM_PINS-1:0][7:0]  dest_i,
  input  logic [NUM_PINS-1:0]       lvl_i,
  input  logic [NUM_PINS-1:0]       pend_i,
  input  logic                      eoi_valid_i,
  input  logic [7:0]                eoi_vector_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [7:0]                vec_o,
  output logic [2:0]                mode_o,
  output logic                      dl_o,
  output logic [7:0]                dest_o,
  output logic                      ext_o,
  output logic [NUM_PINS-1:0]       clr_o,
  output logic [NUM_PINS-1:0]       rirr_o
);
  logic [IDX_W-1:0] ptr_q, src_q;
  logic             set_rirr_q;
  logic [2:0]       cur_mode;
  logic             cur_lvl, cur_hold, fire, acc;

  assign cur_mode = mode_i[ptr_q];
  assign cur_lvl  = trig_i[ptr_q] && !mode_edge_only(cur_mode);
  assign cur_hold = cur_lvl && mode_uses_rirr(cur_mode);
  assign fire = !valid_o && !mask_i[ptr_q] && !mode_reserved(cur_mode) &&
                (cur_lvl ? (lvl_i[ptr_q] && !(cur_hold && rirr_o[ptr_q]))
                         : pend_i[ptr_q]);
  assign acc  = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      src_q      <= '0;
      valid_o    <= 1'b0;
      set_rirr_q <= 1'b0;
      vec_o      <= '0;
      mode_o     <= '0;
      dl_o       <= 1'b0;
      dest_o     <= '0;
      ext_o      <= 1'b0;
    end else begin
      if (!valid_o)
        ptr_q <= (ptr_q == IDX_W'(NUM_PINS - 1)) ? '0 : ptr_q + 1'b1;
      if (acc) valid_o <= 1'b0;
      if (fire) begin
        valid_o    <= 1'b1;
        src_q      <= ptr_q;
        set_rirr_q <= cur_hold;
        mode_o     <= cur_mode;
        vec_o      <= (cur_mode == DM_SMI || cur_mode == DM_NMI) ? 8'h00 : vec_i[ptr_q];
        dl_o       <= dl_i[ptr_q];
        dest_o     <= dl_i[ptr_q] ? dest_i[ptr_q] : {4'b0, dest_i[ptr_q][3:0]};
        ext_o      <= (cur_mode == DM_EXTINT);
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic hit, eoi_hit;
    assign hit     = acc && (src_q == IDX_W'(g));
    assign eoi_hit = eoi_valid_i && (vec_i[g] == eoi_vector_i);
    assign clr_o[g] = hit;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 rirr_o[g] <= 1'b0;
      else if (hit && set_rirr_q)  rirr_o[g] <= 1'b1;
      else if (eoi_hit)            rirr_o[g] <= 1'b0;
    end
  end

  AST_HOLD_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable({vec_o, mode_o, dl_o, dest_o, ext_o})); // R11
  AST_NO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !mode_reserved(mode_o)); // R10
  AST_RIRR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) && set_rirr_q |-> !rirr_o[src_q]); // R6
  AST_NMI_NO_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (mode_o == DM_NMI || mode_o == DM_INIT) |-> !set_rirr_q); // R7
  AST_ZERO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (mode_o == DM_SMI || mode_o == DM_NMI) |-> vec_o == 8'h00); // R8
  AST_PHYS_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !dl_o |-> dest_o[7:4] == 4'h0); // R5
endmodule

// File: rtl/irq_redir_dispatch.sv
module irq_redir_dispatch
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                reg_we_i,
  input  logic [IDX_W-1:0]    reg_addr_i,
  input  logic [63:0]         reg_wdata_i,
  output logic [63:0]         reg_rdata_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_mode_o,
  output logic                msg_dest_logical_o,
  output logic [7:0]          msg_dest_o,
  output logic                msg_ext_o
);
  logic [ENTRY_W-1:0]       tbl [NUM_PINS];
  logic [NUM_PINS-1:0][7:0] vec, dest;
  logic [NUM_PINS-1:0][2:0] mode;
  logic [NUM_PINS-1:0]      dl, trig, mask, lvl, pend, clr, rirr;

  irq_redir_table #(.NUM_PINS(NUM_PINS)) i_table (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .tbl_o(tbl)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fld
    assign vec[g]  = tbl[g][7:0];
    assign mode[g] = tbl[g][MODE_LSB +: 3];
    assign dl[g]   = tbl[g][DSTM_BIT];
    assign trig[g] = tbl[g][TRIG_BIT];
    assign mask[g] = tbl[g][MASK_BIT];
    assign dest[g] = tbl[g][DEST_LSB +: 8];
  end

  irq_edge_capture #(.NUM_PINS(NUM_PINS)) i_edge (
    .clk_i, .rst_ni, .irq_i, .clr_i(clr), .lvl_o(lvl), .pend_o(pend)
  );

  irq_redir_scan #(.NUM_PINS(NUM_PINS)) i_scan (
    .clk_i, .rst_ni, .vec_i(vec), .mode_i(mode), .dl_i(dl), .trig_i(trig),
    .mask_i(mask), .dest_i(dest), .lvl_i(lvl), .pend_i(pend),
    .eoi_valid_i, .eoi_vector_i, .ready_i(msg_ready_i),
    .valid_o(msg_valid_o), .vec_o(msg_vector_o), .mode_o(msg_mode_o),
    .dl_o(msg_dest_logical_o), .dest_o(msg_dest_o), .ext_o(msg_ext_o),
    .clr_o(clr), .rirr_o(rirr)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) < NUM_PINS) begin
      reg_rdata_o           = tbl[reg_addr_i];
      reg_rdata_o[RIRR_BIT] = rirr[reg_addr_i];
    end
  end

  AST_EXT_ONLY_EXTINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ext_o |-> msg_mode_o == 3'b111); // R9
endmodule

// File: tb/test_irq_redir_dispatch.sv
module test_irq_redir_dispatch;
  localparam int N = 24;
  localparam int IW = $clog2(N);
  localparam int TO = 4 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          we = 1'b0;
  logic [IW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic          eoi_v = 1'b0;
  logic [7:0]    eoi_vec = '0;
  logic          mv, ready = 1'b0, mdl, mext;
  logic [7:0]    mvec, mdest;
  logic [2:0]    mmode;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  irq_redir_dispatch #(.NUM_PINS(N)) i_irq_redir_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eoi_valid_i(eoi_v),
    .eoi_vector_i(eoi_vec), .msg_valid_o(mv), .msg_ready_i(ready),
    .msg_vector_o(mvec), .msg_mode_o(mmode), .msg_dest_logical_o(mdl),
    .msg_dest_o(mdest), .msg_ext_o(mext)
  );

  function automatic logic [63:0] mk(logic [7:0] v, logic [2:0] m, logic d,
                                     logic t, logic k, logic [7:0] ds);
    logic [63:0] e = '0;
    e[7:0] = v; e[10:8] = m; e[11] = d; e[15] = t; e[16] = k; e[63:56] = ds;
    return e;
  endfunction

  // {vector, mode, dest_logical, dest, ext}
  function automatic logic [20:0] exp_msg(logic [63:0] e);
    logic [7:0] v = (e[10:8] == 3'b010 || e[10:8] == 3'b100) ? 8'h00 : e[7:0];
    logic [7:0] d = e[11] ? e[63:56] : {4'b0, e[59:56]};
    return {v, e[10:8], e[11], d, e[10:8] == 3'b111};
  endfunction

  function automatic logic [20:0] got_msg();
    return {mvec, mmode, mdl, mdest, mext};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [63:0] d);
    addr = IW'(idx); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int idx, output logic [63:0] d);
    addr = IW'(idx); #1; d = rdata;
  endtask

  task automatic wait_msg(int to, output bit got);
    got = 1'b0;
    for (int i = 0; i < to; i++) begin
      if (mv) begin got = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic take();
    ready = 1'b1; @(negedge clk); ready = 1'b0;
  endtask

  task automatic count_msgs(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (mv) c++;
      @(negedge clk);
    end
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_vec = v; eoi_v = 1'b1; @(negedge clk); eoi_v = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [63:0] r, e;
    logic [20:0] m0;
    bit got;
    int c;
    logic [7:0] seq [3];
    void'($urandom(32'd20250607));

    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 64'(mv), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid idle", 64'(mv), 64'd0);
    rd(0, r);  chk("R1 entry0 reset", r, 64'h1_0000);
    rd(23, r); chk("R1 entry23 reset", r, 64'h1_0000);

    // R2: bit 14 not writable, out-of-range ignored
    wr(5, '1);
    rd(5, r); chk("R2 readback bit14 clear", r, 64'hFFFF_FFFF_FFFF_BFFF);
    wr(30, '1);
    rd(30, r); chk("R2 out-of-range read", r, 64'd0);
    wr(5, mk(8'h45, 3'b000, 1'b0, 1'b0, 1'b1, 8'h00));

    // R3/R5/R11: fixed edge, physical dest with high nibble set
    e = mk(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 8'hA7);
    wr(4, e);
    irq[4] = 1'b1;
    wait_msg(TO, got);
    chk("R3 edge message", 64'(got), 64'd1);
    chk("R5 physical fields", 64'(got_msg()), 64'(exp_msg(e)));
    m0 = got_msg();
    repeat (5) @(negedge clk);
    chk("R11 valid held", 64'(mv), 64'd1);
    chk("R11 fields held", 64'(got_msg()), 64'(m0));
    take();
    count_msgs(3 * N, c);
    chk("R3 no repeat while high", 64'(c), 64'd0);
    irq[4] = 1'b0;
    wr(4, e | 64'h1_0000);

    // R4: edge seen while masked is delivered on unmask
    e = mk(8'h46, 3'b001, 1'b1, 1'b0, 1'b1, 8'h3C);
    wr(6, e);
    irq[6] = 1'b1;
    count_msgs(2 * N, c);
    chk("R4 masked silent", 64'(c), 64'd0);
    irq[6] = 1'b0;
    wr(6, e & ~64'h1_0000);
    wait_msg(TO, got);
    chk("R4 delivered after unmask", 64'(got), 64'd1);
    chk("R5 logical fields", 64'(got_msg()), 64'(exp_msg(e & ~64'h1_0000)));
    take();
    wr(6, e);

    // R6: level fixed with remote-IRR
    e = mk(8'h48, 3'b000, 1'b0, 1'b1, 1'b0, 8'h02);
    wr(8, e);
    irq[8] = 1'b1;
    wait_msg(TO, got);
    chk("R6 level message", 64'(got), 64'd1);
    chk("R6 level vector", 64'(mvec), 64'h48);
    take();
    rd(8, r); chk("R6 remote-IRR set", 64'(r[14]), 64'd1);
    count_msgs(2 * N, c);
    chk("R6 blocked while set", 64'(c), 64'd0);
    eoi(8'h49);
    rd(8, r); chk("R6 foreign EOI kept bit", 64'(r[14]), 64'd1);
    count_msgs(N, c);
    chk("R6 foreign EOI no message", 64'(c), 64'd0);
    eoi(8'h48);
    rd(8, r); chk("R6 matching EOI clears", 64'(r[14]), 64'd0);
    wait_msg(TO, got);
    chk("R6 message after EOI", 64'(got), 64'd1);
    take();
    irq[8] = 1'b0;
    eoi(8'h48);
    wr(8, e | 64'h1_0000);

    // R7: NMI mis-set to level fires every lap
    e = mk(8'h4A, 3'b100, 1'b0, 1'b1, 1'b0, 8'h01);
    wr(10, e);
    irq[10] = 1'b1;
    wait_msg(TO, got);
    chk("R7 NMI first", 64'(got), 64'd1);
    chk("R7 NMI fields", 64'(got_msg()), 64'(exp_msg(e)));
    take();
    wait_msg(2 * N, got);
    chk("R7 NMI repeats", 64'(got), 64'd1);
    take();
    rd(10, r); chk("R7 no remote-IRR", 64'(r[14]), 64'd0);
    irq[10] = 1'b0;
    repeat (3) @(negedge clk);
    if (mv) take();
    count_msgs(2 * N, c);
    chk("R7 stops when low", 64'(c), 64'd0);
    wr(10, e | 64'h1_0000);

    // R8: SMI with level bit behaves as edge, vector 0
    e = mk(8'h4C, 3'b010, 1'b0, 1'b1, 1'b0, 8'h05);
    wr(12, e);
    irq[12] = 1'b1;
    wait_msg(TO, got);
    chk("R8 SMI message", 64'(got), 64'd1);
    chk("R8 SMI vector zero", 64'(mvec), 64'h00);
    take();
    count_msgs(2 * N, c);
    chk("R8 SMI single shot", 64'(c), 64'd0);
    irq[12] = 1'b0;
    wr(12, e | 64'h1_0000);

    // R9: ExtINT flag, level bit ignored
    e = mk(8'h4D, 3'b111, 1'b1, 1'b1, 1'b0, 8'hF0);
    wr(13, e);
    irq[13] = 1'b1;
    wait_msg(TO, got);
    chk("R9 ExtINT message", 64'(got), 64'd1);
    chk("R9 ExtINT fields", 64'(got_msg()), 64'(exp_msg(e)));
    take();
    count_msgs(2 * N, c);
    chk("R9 ExtINT single shot", 64'(c), 64'd0);
    irq[13] = 1'b0;
    wr(13, e | 64'h1_0000);

    // R10: reserved modes silent
    wr(14, mk(8'h4E, 3'b011, 1'b0, 1'b0, 1'b0, 8'h00));
    wr(15, mk(8'h4F, 3'b110, 1'b0, 1'b0, 1'b0, 8'h00));
    irq[14] = 1'b1; irq[15] = 1'b1;
    count_msgs(3 * N, c);
    chk("R10 reserved silent", 64'(c), 64'd0);
    irq[14] = 1'b0; irq[15] = 1'b0;
    wr(14, 64'h1_0000); wr(15, 64'h1_0000);

    // R12: cyclic order of simultaneous edges
    wr(0,  mk(8'h20, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00));
    wr(9,  mk(8'h29, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00));
    wr(20, mk(8'h34, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00));
    irq[0] = 1'b1; irq[9] = 1'b1; irq[20] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_msg(TO, got);
      seq[k] = got ? mvec : 8'hFF;
      if (got) take();
    end
    chk("R12 cyclic order", 64'(({seq[0], seq[1], seq[2]} == 24'h202934) ||
                               ({seq[0], seq[1], seq[2]} == 24'h293420) ||
                               ({seq[0], seq[1], seq[2]} == 24'h342029)), 64'd1);
    irq[0] = 1'b0; irq[9] = 1'b0; irq[20] = 1'b0;
    wr(0, 64'h1_0000); wr(9, 64'h1_0000); wr(20, 64'h1_0000);

    // random edge trials, R5/R8/R9 field checks
    for (int t = 0; t < 24; t++) begin
      int p = 16 + int'($urandom_range(7, 0));
      logic [2:0] md;
      case ($urandom_range(5, 0))
        0: md = 3'b000; 1: md = 3'b001; 2: md = 3'b010;
        3: md = 3'b100; 4: md = 3'b101; default: md = 3'b111;
      endcase
      e = mk(8'($urandom_range(254, 16)), md, 1'($urandom()),
             1'b0, 1'b0, 8'($urandom()));
      wr(p, e);
      irq[p] = 1'b1;
      wait_msg(TO, got);
      chk("R5 random message", 64'(got), 64'd1);
      chk("R5 random fields", 64'(got_msg()), 64'(exp_msg(e)));
      if (got) take();
      irq[p] = 1'b0;
      wr(p, e | 64'h1_0000);
    end
    count_msgs(2 * N, c);
    chk("R3 idle after trials", 64'(c), 64'd0);

    finish_run();
  end
endmodule